// File: doc/BRIEF.md
# Inter-Core Mailbox Bank

This block holds a bank of 32-bit mailboxes through which processor cores signal one another. With the default parameters there are four cores, each owning four mailboxes, for sixteen in total. A core raises an event on another core by setting bits in one of that core's mailboxes. The receiving core acknowledges by clearing the bits it has handled. A mailbox can also carry a whole 32-bit word, such as the address at which a sleeping core should start executing.

Software reaches every mailbox through two address windows on a simple synchronous register bus. A write into the set window ORs the data into the mailbox. A write into the clear window removes the bits that are written as ones. Reads from either window return the contents unchanged. Every mailbox drives its own level interrupt, which is high for as long as any of its bits is set.

Top module: `ipi_mailbox_bank`

## Requirements
- R1: After reset every mailbox holds zero, every interrupt output is low and the read data bus reads zero.
- R2: The set address of mailbox b of core c is 0x80 + 16*c + 4*b. A write there makes the mailbox equal to its old value OR the write data.
- R3: The clear address of mailbox b of core c is 0xC0 + 16*c + 4*b. A write there clears the mailbox bits that are one in the write data and leaves the others unchanged.
- R4: Interrupt output bit (4*c + b) is high exactly while mailbox b of core c is nonzero. It follows the contents from the clock edge that performs the write.
- R5: A full 32-bit word written through the set port into a mailbox that holds zero reads back bit for bit.
- R6: A read from a mapped set or clear address returns the mailbox contents on the read data bus after the clock edge that samples the read enable, and it leaves the mailbox unchanged. After an edge with the read enable low, the read data bus is zero.
- R7: A read and a write to the same mailbox in the same cycle return the contents from before that write. The write still takes effect.
- R8: Addresses below 0x80, and addresses whose two low bits are not zero, are unmapped. A write to one changes no mailbox, and a read from one returns zero.
- R9: A write to one mailbox leaves every other mailbox and every other interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the read strobe |
| mbox_irq | output | 16 | Level interrupt per mailbox, index 4*core + mailbox |

## Verification
The bench ORs a second pattern into a mailbox that already holds data. A design that overwrote instead of merging would lose the first pattern there. It clears part of a mailbox and checks that only that mailbox's interrupt drops when its last bit goes, which catches inverted clear masks and interrupts wired to the wrong index. It reads and writes the same mailbox in one cycle, and a read port placed after the update would return the new value there. It writes all ones to misaligned and low offsets, which would corrupt a mailbox in any decoder that ignores the low address bits or the window bounds.

// File: rtl/ipi_mbox_pkg.sv
// Package: ipi_mbox_pkg
// Holds the types shared by the mailbox bank modules.
// Assumes nothing beyond a standard SystemVerilog compile order (package first).
package ipi_mbox_pkg;

    // Which address window a bus address falls into.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

    // True when a byte address is aligned to a 32-bit word.
    function automatic logic is_word_aligned(input logic [1:0] low_bits);
        return low_bits == 2'b00;
    endfunction

endpackage

// File: rtl/ipi_mbox_decode.sv
// Module: ipi_mbox_decode
// Maps a bus address onto a mailbox index and a window (set or clear).
// It produces one-hot set and clear strobes, plus a read strobe and a read index.
// Assumes that NUM_BOXES is a power of two, that both windows are NUM_BOXES words
// long, and that the windows do not overlap. Unaligned addresses map to nothing.
module ipi_mbox_decode
    import ipi_mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BOXES = 16,
    parameter int SET_BASE  = 32'h80,
    parameter int CLR_BASE  = 32'hC0,
    localparam int IDX_W    = $clog2(NUM_BOXES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    output logic [NUM_BOXES-1:0] set_hit,
    output logic [NUM_BOXES-1:0] clr_hit,
    output logic                 rd_hit,
    output logic [IDX_W-1:0]     rd_idx
);

    localparam int WIN_BYTES = NUM_BOXES * 4;

    logic [31:0]      addr32;
    win_e             win;
    logic [IDX_W-1:0] idx;

    assign addr32 = 32'(addr);

    // Classify the address into a window and compute the word index inside it.
    always_comb begin
        win = WIN_NONE;
        idx = '0;
        if (is_word_aligned(addr[1:0])) begin
            if (addr32 >= 32'(SET_BASE) && addr32 < 32'(SET_BASE + WIN_BYTES)) begin
                win = WIN_SET;
                idx = IDX_W'((addr32 - 32'(SET_BASE)) >> 2);
            end else if (addr32 >= 32'(CLR_BASE) && addr32 < 32'(CLR_BASE + WIN_BYTES)) begin
                win = WIN_CLR;
                idx = IDX_W'((addr32 - 32'(CLR_BASE)) >> 2);
            end
        end
    end

    // One strobe pair per mailbox: set and clear gated by the write enable.
    for (genvar i = 0; i < NUM_BOXES; i++) begin : g_hit
        assign set_hit[i] = wr_en && (win == WIN_SET) && (idx == IDX_W'(i));
        assign clr_hit[i] = wr_en && (win == WIN_CLR) && (idx == IDX_W'(i));
    end

    // A read is accepted only when its address hits one of the windows.
    assign rd_hit = rd_en && (win != WIN_NONE);
    assign rd_idx = idx;

    // R2/R3: at most one mailbox strobe per cycle across both windows.
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_hit, clr_hit}));

    // R8: without a write enable, no mailbox strobe may fire.
    a_r8_no_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (set_hit == '0 && clr_hit == '0));

    // R8: an unaligned address never produces a strobe.
    a_r8_unaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> (set_hit == '0 && clr_hit == '0 && !rd_hit));

endmodule

// File: rtl/ipi_mbox_cell.sv
// Module: ipi_mbox_cell
// A single mailbox register with OR-in (set) and mask-out (clear) updates.
// When both strobes are active in one cycle, the clear is applied first and the
// set second. The level interrupt is high while any bit is set.
// Assumes the strobes come from a decoder and last one cycle each.
module ipi_mbox_cell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              irq
);

    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;

    // Build the masks that the update applies this cycle.
    always_comb begin
        set_mask = set_en ? wdata : '0;
        clr_mask = clr_en ? wdata : '0;
    end

    // Mailbox storage: reset to zero, then clear first and set second.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_mask) | set_mask;
    end

    // The level interrupt follows the contents being nonzero.
    assign irq = |q;

    // R2: a set keeps every old bit and adds the written ones.
    a_r2_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> (q == ($past(q) | $past(wdata))));

    // R3: after a clear, none of the written-one bits remain set.
    a_r3_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));

    // R3: a clear never raises a bit that was low.
    a_r3_clear_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & ~$past(q)) == '0));

    // R9: with no strobe, the mailbox holds its value.
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/ipi_mbox_rdport.sv
// Module: ipi_mbox_rdport
// Registered read port: on an accepted read it captures the selected mailbox,
// and otherwise it drives zero. Because it samples the contents present in the
// same cycle as the read, a concurrent write is not yet visible.
// Assumes NUM_BOXES is a power of two, so every index is in range.
module ipi_mbox_rdport #(
    parameter int DATA_W    = 32,
    parameter int NUM_BOXES = 16,
    localparam int IDX_W    = $clog2(NUM_BOXES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] boxes [NUM_BOXES],
    output logic [DATA_W-1:0] rdata
);

    // Capture the selected mailbox on a hit, or return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_hit) rdata <= boxes[rd_idx];
        else             rdata <= '0;
    end

    // R6/R8: an edge without an accepted read leaves the bus at zero.
    a_r6_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (rdata == '0));

endmodule

// File: rtl/ipi_mailbox_bank.sv
// Module: ipi_mailbox_bank (top)
// A bank of NUM_CORES x BOXES_PER_CORE mailboxes on a single-cycle register bus.
// Set window: SET_BASE + 4*(core*BOXES_PER_CORE + box). The clear window has the
// same layout at CLR_BASE. mbox_irq bit (core*BOXES_PER_CORE + box) is high while
// that mailbox is nonzero.
// Assumes at most one access per cycle per enable and a synchronous active-low reset.
module ipi_mailbox_bank #(
    parameter int NUM_CORES      = 4,
    parameter int BOXES_PER_CORE = 4,
    parameter int DATA_W         = 32,
    parameter int ADDR_W         = 8,
    parameter int SET_BASE       = 32'h80,
    parameter int CLR_BASE       = 32'hC0,
    localparam int NUM_BOXES     = NUM_CORES * BOXES_PER_CORE,
    localparam int IDX_W         = $clog2(NUM_BOXES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rd_en,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_BOXES-1:0] mbox_irq
);

    logic [NUM_BOXES-1:0] set_hit;
    logic [NUM_BOXES-1:0] clr_hit;
    logic                 rd_hit;
    logic [IDX_W-1:0]     rd_idx;
    logic [DATA_W-1:0]    boxes [NUM_BOXES];

    // Address decoder: turns the bus access into per-mailbox strobes.
    ipi_mbox_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BOXES (NUM_BOXES),
        .SET_BASE  (SET_BASE),
        .CLR_BASE  (CLR_BASE)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr_en   (bus_wr_en),
        .rd_en   (bus_rd_en),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .rd_hit  (rd_hit),
        .rd_idx  (rd_idx)
    );

    // Mailbox array: one cell per core and mailbox slot.
    for (genvar i = 0; i < NUM_BOXES; i++) begin : g_box
        ipi_mbox_cell #(
            .DATA_W (DATA_W)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (set_hit[i]),
            .clr_en (clr_hit[i]),
            .wdata  (bus_wdata),
            .q      (boxes[i]),
            .irq    (mbox_irq[i])
        );

        // R4: a nonzero set raises this mailbox's interrupt at the next edge.
        a_r4_irq_after_set: assert property (@(posedge clk) disable iff (!rst_n)
            (set_hit[i] && bus_wdata != '0) |=> mbox_irq[i]);

        // R4: clearing with all ones drops the interrupt at the next edge.
        a_r4_irq_after_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[i] && !set_hit[i] && bus_wdata == '1) |=> !mbox_irq[i]);
    end

    // Read port: registered data from the selected mailbox.
    ipi_mbox_rdport #(
        .DATA_W    (DATA_W),
        .NUM_BOXES (NUM_BOXES)
    ) u_rdport (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_hit),
        .rd_idx (rd_idx),
        .boxes  (boxes),
        .rdata  (bus_rdata)
    );

    // R9: a single write changes at most one interrupt line per cycle.
    a_r9_one_irq_moves: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mbox_irq ^ $past(mbox_irq)) <= 1);

endmodule

// File: tb/ipi_mailbox_bank_test.sv
`timescale 1ns/1ps
// Directed bench for ipi_mailbox_bank. Each scenario task checks its own results
// against a mailbox model that the bench keeps from the requirements.
module ipi_mailbox_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [15:0] irq;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] model [16];

    always #10 clk = ~clk;

    ipi_mailbox_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr_en (wr_en),
        .bus_wdata (wdata),
        .bus_rd_en (rd_en),
        .bus_rdata (rdata),
        .mbox_irq  (irq)
    );

    function automatic logic [7:0] set_addr(input int idx);
        return 8'(32'h80 + 4 * idx);
    endfunction

    function automatic logic [7:0] clr_addr(input int idx);
        return 8'(32'hC0 + 4 * idx);
    endfunction

    function automatic logic [15:0] model_irq();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) v[i] = (model[i] != 0);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic mb_set(input int idx, input logic [31:0] d);
        bus_write(set_addr(idx), d);
        model[idx] = model[idx] | d;
    endtask

    task automatic mb_clr(input int idx, input logic [31:0] d);
        bus_write(clr_addr(idx), d);
        model[idx] = model[idx] & ~d;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int i = 0; i < 16; i++) begin
            bus_read(set_addr(i), d);
            chk(req, d, model[i]);
        end
        chk(req, 32'(irq), 32'(model_irq()));
    endtask

    // R1: state out of reset.
    task automatic t_reset();
        for (int i = 0; i < 16; i++) model[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        check_all("R1 mailboxes");
    endtask

    // R2, R4, R9: distinct values in every mailbox, then a second OR into one.
    task automatic t_set_merge();
        for (int i = 0; i < 16; i++) mb_set(i, (32'h1 << i) | (32'(i) << 24));
        check_all("R9 independent");
        chk("R4 all raised", 32'(irq), 32'hFFFF);
        mb_set(5, 32'h00F0_0000);
        check_all("R2 or-merge");
    endtask

    // R3, R4, R6: partial clear, read via clear window, full clear drops one irq.
    task automatic t_clear();
        logic [31:0] d;
        mb_clr(5, 32'h0050_0020);
        bus_read(clr_addr(5), d);
        chk("R3 partial clear", d, model[5]);
        chk("R6 read no side effect", 32'(irq), 32'(model_irq()));
        mb_clr(0, 32'hFFFF_FFFF);
        chk("R4 irq drops", 32'(irq), 32'hFFFE);
        check_all("R3 others kept");
    endtask

    // R5: a full address word through the set port of core 2, mailbox 3.
    task automatic t_boot_word();
        logic [31:0] d;
        mb_clr(11, 32'hFFFF_FFFF);
        mb_set(11, 32'h8000_1234);
        bus_read(8'hAC, d);
        chk("R5 full word", d, 32'h8000_1234);
        mb_clr(11, 32'hFFFF_FFFF);
        mb_set(11, 32'hFFFF_FFFF);
        bus_read(clr_addr(11), d);
        chk("R5 all ones", d, 32'hFFFF_FFFF);
    endtask

    // R8: writes to unmapped offsets change nothing, and reads there return zero.
    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h7C, 32'hFFFF_FFFF);
        bus_write(8'h85, 32'hFFFF_FFFF);
        bus_write(8'hC2, 32'hFFFF_FFFF);
        check_all("R8 writes ignored");
        bus_read(8'h10, d);
        chk("R8 low read", d, 32'h0);
        bus_read(8'h85, d);
        chk("R8 unaligned read", d, 32'h0);
    endtask

    // R7: read and write of one mailbox in the same cycle.
    task automatic t_read_write_same();
        logic [31:0] old_v;
        logic [31:0] d;
        old_v = model[7];
        @(negedge clk);
        addr = set_addr(7); wdata = 32'h0A00_0000; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        model[7] = model[7] | 32'h0A00_0000;
        chk("R7 pre-write value", rdata, old_v);
        bus_read(set_addr(7), d);
        chk("R7 write applied", d, model[7]);
    endtask

    // R6: the read bus returns to zero after an idle edge.
    task automatic t_idle_zero();
        logic [31:0] d;
        bus_read(set_addr(3), d);
        chk("R6 read value", d, model[3]);
        @(negedge clk);
        chk("R6 idle zero", rdata, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        t_reset();
        t_set_merge();
        t_clear();
        t_boot_word();
        t_unmapped();
        t_read_write_same();
        t_idle_zero();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule